// File: doc/BRIEF.md
# Dithered Fine-Resolution PWM Channel

This block produces one pulse-width-modulated output from an 8-bit duty word, running directly from the system clock. The duty word is split into two parts. The upper field sets a base high time within a short sub-period. The lower field chooses how many sub-periods of a frame receive one extra high clock.

Because the pulse repeats every sub-period instead of once per frame, the output frequency is several times higher than a plain 8-bit counter would give. The average duty over a whole frame still has full 8-bit resolution. A parameter selects one of two splits: a four-sub-period frame of 64 clocks each, or a two-sub-period frame of 128 clocks each.

The pin is gated by an output-enable bit and a port data bit. Data 1 lets the waveform through and data 0 holds the pin low. A duty word change takes effect only at the next frame boundary.

Top module: `dither_pwm_channel`

## Requirements
- R1: While `rst` is high, `pwm_pin` is 0 on the next clock. The frame position returns to clock 0 of sub-period 0, and the working duty value is taken from `duty_reg`.
- R2: The frame position advances by one every clock and wraps from its last clock back to clock 0 of sub-period 0. A frame is 2^FRAC_W sub-periods of 2^(DUTY_W-FRAC_W) clocks, which is 256 clocks in both splits.
- R3: The working duty is split as base = bits [DUTY_W-1:FRAC_W] and extra = bits [FRAC_W-1:0]. Sub-period i (numbered from 0) is high for base+1 clocks when i < extra, and for base clocks otherwise. The total high time over a frame therefore equals the duty value.
- R4: Within each sub-period the pin is high from the first clock until the clock count reaches the high count, then low. The pin is registered and shows the level for frame position p one clock after position p.
- R5: When `port_data` is 0, `pwm_pin` is 0 on the next clock.
- R6: When `output_en` is 0, `pwm_pin` is 0 on the next clock.
- R7: A new `duty_reg` value is captured only on the last clock of a frame and is used from the start of the next frame.
- R8: The frame position keeps advancing while the output is gated off. Re-enabling resumes at the current frame position, not at a new frame.
- R9: Edge cases follow the rule in R3:
  - A sub-period with base 0 and i >= extra is low for the whole sub-period.
  - A sub-period with the largest base value and i < extra is high for the whole sub-period.
  - Duty 0x00 gives 0 high clocks per frame, and duty 0xFF gives 255 high clocks per frame.
- R10: With FRAC_W = 1 the frame has two sub-periods of 128 clocks, with base = bits [7:1] and extra = bit 0, under the same rule as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the PWM counter advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_reg | input | DUTY_W | Duty word: base field in the upper bits, extra field in the lower FRAC_W bits |
| output_en | input | 1 | 1 = pin configured as output; 0 holds the pin low |
| port_data | input | 1 | 1 = PWM waveform on the pin; 0 forces the pin low |
| pwm_pin | output | 1 | Registered pin level |

## Verification
If the frame counter skips or stalls, the rising edges of the pin stop falling on sub-period starts. The error shows at the next sub-period boundary, within 64 clocks. If the duty word is captured at the wrong moment or with the wrong field split, the high count of some sub-period changes. The total high time over a frame then stops matching the duty value. This shows within one frame, or 256 clocks, of a duty change. Gating errors show on the clock right after `port_data` or `output_en` drops.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;

  // Width of the in-sub-period position for a given split
  function automatic int unsigned sub_width(input int unsigned duty_w,
                                            input int unsigned frac_w);
    return duty_w - frac_w;
  endfunction

  // Number of sub-periods in one frame
  function automatic int unsigned slot_count(input int unsigned frac_w);
    return 1 << frac_w;
  endfunction

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] frame_pos,
  output logic             frame_last
);

  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) frame_pos <= '0;
    else     frame_pos <= frame_pos + 1'b1;
  end

  assign frame_last = (frame_pos == POS_MAX);

  // R2: wrap from last clock to frame start
  assert_wrap_to_start_R2: assert property (@(posedge clk) disable iff (rst)
    frame_last |=> (frame_pos == '0));

  // R2, R8: one step per clock, regardless of gating
  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> (frame_pos == $past(frame_pos) + 1'b1));

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] duty_work
);

  always_ff @(posedge clk) begin
    if (rst || capture) duty_work <= duty_in;
  end

  // R7: working duty only changes at the frame boundary
  assert_hold_midframe_R7: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(duty_work));

endmodule

// File: rtl/pwm_slot_compare.sv
module pwm_slot_compare #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic [DUTY_W-1:0]          frame_pos,
  input  logic [DUTY_W-1:0]          duty_work,
  output logic [DUTY_W-FRAC_W-1:0]   sub_pos,
  output logic [DUTY_W-FRAC_W:0]     high_cnt,
  output logic                       level_next
);

  localparam int unsigned SUB_W = dither_pwm_pkg::sub_width(DUTY_W, FRAC_W);

  logic [FRAC_W-1:0] slot_idx;
  logic [FRAC_W-1:0] extra_fld;
  logic [SUB_W-1:0]  base_fld;
  logic              gets_extra;

  always_comb begin
    sub_pos    = frame_pos[SUB_W-1:0];
    slot_idx   = frame_pos[DUTY_W-1:SUB_W];
    base_fld   = duty_work[DUTY_W-1:FRAC_W];
    extra_fld  = duty_work[FRAC_W-1:0];
    gets_extra = (slot_idx < extra_fld);
    high_cnt   = {1'b0, base_fld} + {{SUB_W{1'b0}}, gets_extra};
    level_next = ({1'b0, sub_pos} < high_cnt);
  end

endmodule

// File: rtl/dither_pwm_channel.sv
module dither_pwm_channel #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_reg,
  input  logic              output_en,
  input  logic              port_data,
  output logic              pwm_pin
);

  localparam int unsigned SUB_W = dither_pwm_pkg::sub_width(DUTY_W, FRAC_W);

  logic [DUTY_W-1:0] frame_pos;
  logic              frame_last;
  logic [DUTY_W-1:0] duty_work;
  logic [SUB_W-1:0]  sub_pos;
  logic [SUB_W:0]    high_cnt;
  logic              level_next;

  pwm_frame_counter #(.CNT_W(DUTY_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .frame_pos  (frame_pos),
    .frame_last (frame_last)
  );

  pwm_duty_shadow #(.DUTY_W(DUTY_W)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .capture   (frame_last),
    .duty_in   (duty_reg),
    .duty_work (duty_work)
  );

  pwm_slot_compare #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_compare (
    .frame_pos  (frame_pos),
    .duty_work  (duty_work),
    .sub_pos    (sub_pos),
    .high_cnt   (high_cnt),
    .level_next (level_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_pin <= 1'b0;
    else     pwm_pin <= output_en & port_data & level_next;
  end

  // R5: data bit 0 forces the pin low
  assert_data_forces_low_R5: assert property (@(posedge clk) disable iff (rst)
    !port_data |=> !pwm_pin);

  // R6: pin not configured as output stays low
  assert_dir_forces_low_R6: assert property (@(posedge clk) disable iff (rst)
    !output_en |=> !pwm_pin);

  // R4: each enabled sub-period with a non-zero count starts high
  assert_rise_at_sub_start_R4: assert property (@(posedge clk) disable iff (rst)
    (output_en && port_data && sub_pos == '0 && high_cnt != '0) |=> pwm_pin);

  // R3: once the count reaches the high count the pin is low
  assert_low_past_count_R3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, sub_pos} >= high_cnt) |=> !pwm_pin);

endmodule

// File: tb/test_dither_pwm_channel.sv
`timescale 1ns/1ps
module test_dither_pwm_channel;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] duty;
  logic       oe;
  logic       pd;
  logic       pin62;
  logic       pin71;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  int unsigned m_cnt = 0;
  int unsigned m_sh  = 0;
  logic        exp62 = 1'b0;
  logic        exp71 = 1'b0;

  always #2.5 clk = ~clk;

  dither_pwm_channel #(.DUTY_W(8), .FRAC_W(2)) i_dither_pwm_channel (
    .clk(clk), .rst(rst), .duty_reg(duty), .output_en(oe), .port_data(pd), .pwm_pin(pin62)
  );

  dither_pwm_channel #(.DUTY_W(8), .FRAC_W(1)) i_dither_pwm_channel_m71 (
    .clk(clk), .rst(rst), .duty_reg(duty), .output_en(oe), .port_data(pd), .pwm_pin(pin71)
  );

  // Expected level for frame position cnt with working duty sh, from R3/R4
  function automatic logic level_of(input int unsigned cnt, input int unsigned sh,
                                    input int unsigned frac);
    int unsigned sub  = 8 - frac;
    int unsigned pos  = cnt % (1 << sub);
    int unsigned slot = cnt >> sub;
    int unsigned base = sh >> frac;
    int unsigned ext  = sh & ((1 << frac) - 1);
    int unsigned high = base + ((slot < ext) ? 1 : 0);
    return (pos < high);
  endfunction

  // Reference model advanced at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0;
      m_sh  = duty;
      exp62 = 1'b0;
      exp71 = 1'b0;
    end else begin
      exp62 = oe && pd && level_of(m_cnt, m_sh, 2);
      exp71 = oe && pd && level_of(m_cnt, m_sh, 1);
      if (m_cnt == 255) m_sh = duty;
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic string cur_tag();
    if (rst)  return "R1";
    if (!oe)  return "R6";
    if (!pd)  return "R5";
    return tag;
  endfunction

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(cur_tag(), int'(pin62), int'(exp62));
      check(rst ? "R1" : "R10", int'(pin71), int'(exp71));
    end
  endtask

  // Sum high clocks over one frame for both splits; total must equal duty (R3, R9, R10)
  task automatic frame_sum(input string req, input logic [7:0] d);
    int s62 = 0;
    int s71 = 0;
    duty = d;
    tick(512);
    for (int k = 0; k < 256; k++) begin
      tick(1);
      s62 += int'(pin62);
      s71 += int'(pin71);
    end
    check(req, s62, int'(d));
    check("R10", s71, int'(d));
  endtask

  initial begin
    rst = 1'b1; duty = 8'h00; oe = 1'b1; pd = 1'b1;
    tick(4);
    check("R1", int'(pin62), 0);
    rst = 1'b0;
    tick(2);
    check("R1", int'(pin62), 0);

    tag = "R2"; duty = 8'h40; tick(600);
    tag = "R4"; duty = 8'h4E; tick(300);

    tag = "R3";
    frame_sum("R3", 8'h4E);
    frame_sum("R3", 8'hB5);
    tag = "R9";
    frame_sum("R9", 8'h00);
    frame_sum("R9", 8'hFF);
    frame_sum("R9", 8'hFC);
    frame_sum("R9", 8'h03);

    tag = "R7"; duty = 8'h80; tick(300);
    for (int k = 0; k < 10; k++) begin
      duty = (k % 2 == 0) ? 8'h11 : 8'hE7;
      tick(37);
    end
    tick(300);

    tag = "R8"; duty = 8'h9A; tick(100);
    pd = 1'b0; tick(173);
    pd = 1'b1; tick(300);
    oe = 1'b0; tick(211);
    oe = 1'b1; tick(300);

    tag = "R4";
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      duty = 8'($urandom);
      oe   = ($urandom % 8) != 0;
      pd   = ($urandom % 8) != 0;
      tick(50 + int'($urandom % 550));
    end
    oe = 1'b1; pd = 1'b1;
    tick(300);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule